// File: doc/BRIEF.md
# Decrement-and-Branch Loop Controller

This unit resolves the counted-loop control operations of a simple processor core. When the core issues an operation, it passes the loop count register, the result of a condition test, the zero flag, the address of the following instruction and a signed displacement. The unit answers with the value to write back to the count register, a write enable for that register, a branch-taken flag and the address at which fetch continues.

Two families of loop semantics share the datapath. The first tests a condition before it decrements. A true condition leaves the loop at once. Otherwise only the low field of the count is decremented, and the loop ends when that field wraps to all ones. The second family decrements the whole register first and leaves when it reaches zero. Two variants of it also require the zero flag to be set, or to be clear, to keep looping. A guard operation jumps over a loop whose count is already zero and does not decrement. No operation produces or changes a condition flag.

Every operation takes two cycles inside the unit, a decrement cycle and then a decision cycle. Results are presented together with a one-cycle done pulse.

Top module: `loop_ctrl_unit`

## Requirements
- R1: While reset is asserted and after it is released, done_o, count_we_o and taken_o are 0, and count_o and target_o are all zeros.
- R2: With op_i = 0 (test-then-decrement) and cond_i = 1, the loop exits. count_we_o is 0, taken_o is 0, count_o equals count_i, and target_o equals next_pc_i, even when count_i is zero.
- R3: With op_i = 0 and cond_i = 0, the low 16 bits of the count are decremented and the upper bits pass through unchanged, and count_we_o is 1. The loop exits (taken_o = 0) only when the low field becomes 16'hFFFF. A low field that reaches zero still branches.
- R4: For op_i = 0, a taken branch targets next_pc_i plus the full 16-bit disp_i, sign-extended.
- R5: With op_i = 1 (plain loop), the whole count is decremented modulo 2^CNT_W and written back (count_we_o = 1). The branch is taken exactly when the new count is nonzero. cond_i and zf_i have no effect.
- R6: For op_i = 1, 2, 3 and 4, a taken branch targets next_pc_i plus the sign-extended low 8 bits of disp_i. The upper 8 bits of disp_i are ignored.
- R7: op_i = 2 (loop while zero flag set) and op_i = 3 (loop while zero flag clear) decrement and write back as in R5. They branch only when the new count is nonzero and zf_i is 1 (op 2) or 0 (op 3).
- R8: With op_i = 4 (count-zero guard), the branch is taken exactly when count_i is zero. count_we_o is 0 and count_o equals count_i.
- R9: When the loop exits without branching, target_o equals next_pc_i.
- R10: A start accepted at a clock edge makes done_o high for exactly one cycle, beginning after the second following edge. count_we_o and taken_o are high only while done_o is high.
- R11: A start_i seen while an operation is in progress is ignored, and the running operation's results are unaffected.
- R12: Reserved op_i codes 5 to 7 do no write and take no branch, and they return count_o = count_i and target_o = next_pc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Issue an operation; sampled only when idle |
| op_i | input | 3 | Operation code (0 to 4 defined, 5 to 7 reserved) |
| count_i | input | CNT_W | Current loop count register value |
| cond_i | input | 1 | Condition test result for the test-then-decrement form |
| zf_i | input | 1 | Zero flag for the qualified loop forms |
| next_pc_i | input | ADDR_W | Address of the following instruction |
| disp_i | input | WIDE_DISP_W | Signed branch displacement |
| count_o | output | CNT_W | Count value to write back |
| count_we_o | output | 1 | Count register write enable, valid with done_o |
| taken_o | output | 1 | Branch taken, valid with done_o |
| target_o | output | ADDR_W | Address where fetch continues |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit at its default widths: a 32-bit count with a 16-bit low field, 32-bit addresses, and displacement fields of 16 and 8 bits. At these widths a low-field wrap can be set against nonzero upper bits to show that the upper bits are preserved, and a full 32-bit count can go from zero to all ones to show the plain loop wrapping across the whole register. The 16-bit displacement field is wide enough to hold upper-byte garbage that the byte-displacement forms must discard, and both positive and negative extremes of each displacement are reachable.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

    typedef enum logic [2:0] {
        OP_TESTDEC    = 3'd0,
        OP_DECLOOP    = 3'd1,
        OP_DECLOOP_ZS = 3'd2,
        OP_DECLOOP_ZC = 3'd3,
        OP_CNTZ_GUARD = 3'd4
    } lcu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEC    = 2'd1,
        ST_DECIDE = 2'd2
    } lcu_state_e;

endpackage

// File: rtl/lcu_decrement.sv
module lcu_decrement #(
    parameter int CNT_W = 32,
    parameter int LOW_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] full_dec_o,
    output logic [CNT_W-1:0] low_dec_o,
    output logic             low_wrap_o
);
    localparam logic [CNT_W-1:0] ONE_F = CNT_W'(1);
    localparam logic [LOW_W-1:0] ONE_L = LOW_W'(1);

    logic [LOW_W-1:0] low_field;

    assign full_dec_o = cnt_i - ONE_F;
    assign low_field  = cnt_i[LOW_W-1:0] - ONE_L;
    assign low_wrap_o = (low_field == {LOW_W{1'b1}});

    generate
        if (LOW_W < CNT_W) begin : g_split
            assign low_dec_o = {cnt_i[CNT_W-1:LOW_W], low_field};
        end else begin : g_whole
            assign low_dec_o = full_dec_o;
        end
    endgenerate

endmodule

// File: rtl/lcu_decide.sv
module lcu_decide
    import lcu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [2:0]       op_i,
    input  logic             cond_i,
    input  logic             zf_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] full_dec_i,
    input  logic [CNT_W-1:0] low_dec_i,
    input  logic             low_wrap_i,
    output logic             taken_o,
    output logic             we_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wide_o
);
    logic             dec_nonzero;
    logic [CNT_W-1:0] new_cnt;

    assign dec_nonzero = (full_dec_i != '0);

    always_comb begin
        taken_o = 1'b0;
        we_o    = 1'b0;
        new_cnt = cnt_i;
        case (op_i)
            OP_TESTDEC: begin
                if (!cond_i) begin
                    we_o    = 1'b1;
                    new_cnt = low_dec_i;
                    taken_o = !low_wrap_i;
                end
            end
            OP_DECLOOP: begin
                we_o    = 1'b1;
                new_cnt = full_dec_i;
                taken_o = dec_nonzero;
            end
            OP_DECLOOP_ZS: begin
                we_o    = 1'b1;
                new_cnt = full_dec_i;
                taken_o = dec_nonzero && zf_i;
            end
            OP_DECLOOP_ZC: begin
                we_o    = 1'b1;
                new_cnt = full_dec_i;
                taken_o = dec_nonzero && !zf_i;
            end
            OP_CNTZ_GUARD: begin
                taken_o = (cnt_i == '0);
            end
            default: begin
                taken_o = 1'b0;
            end
        endcase
    end

    assign cnt_o  = new_cnt;
    assign wide_o = (op_i == OP_TESTDEC);

endmodule

// File: rtl/lcu_target.sv
module lcu_target #(
    parameter int ADDR_W       = 32,
    parameter int WIDE_DISP_W  = 16,
    parameter int SHORT_DISP_W = 8
) (
    input  logic [ADDR_W-1:0]      next_pc_i,
    input  logic [WIDE_DISP_W-1:0] disp_i,
    input  logic                   wide_i,
    input  logic                   taken_i,
    output logic [ADDR_W-1:0]      target_o
);
    logic [ADDR_W-1:0] wide_ext;
    logic [ADDR_W-1:0] short_ext;

    generate
        if (ADDR_W > WIDE_DISP_W) begin : g_wide_ext
            assign wide_ext = {{(ADDR_W-WIDE_DISP_W){disp_i[WIDE_DISP_W-1]}}, disp_i};
        end else begin : g_wide_trunc
            assign wide_ext = disp_i[ADDR_W-1:0];
        end
        if (ADDR_W > SHORT_DISP_W) begin : g_short_ext
            assign short_ext = {{(ADDR_W-SHORT_DISP_W){disp_i[SHORT_DISP_W-1]}},
                                disp_i[SHORT_DISP_W-1:0]};
        end else begin : g_short_trunc
            assign short_ext = disp_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        if (taken_i) begin
            target_o = next_pc_i + (wide_i ? wide_ext : short_ext);
        end else begin
            target_o = next_pc_i;
        end
    end

endmodule

// File: rtl/loop_ctrl_unit.sv
module loop_ctrl_unit
    import lcu_pkg::*;
#(
    parameter int CNT_W        = 32,
    parameter int ADDR_W       = 32,
    parameter int LOW_W        = 16,
    parameter int WIDE_DISP_W  = 16,
    parameter int SHORT_DISP_W = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic [2:0]             op_i,
    input  logic [CNT_W-1:0]       count_i,
    input  logic                   cond_i,
    input  logic                   zf_i,
    input  logic [ADDR_W-1:0]      next_pc_i,
    input  logic [WIDE_DISP_W-1:0] disp_i,
    output logic [CNT_W-1:0]       count_o,
    output logic                   count_we_o,
    output logic                   taken_o,
    output logic [ADDR_W-1:0]      target_o,
    output logic                   done_o
);
    typedef struct packed {
        lcu_state_e             state;
        logic [2:0]             op;
        logic [CNT_W-1:0]       cnt;
        logic                   cond;
        logic                   zf;
        logic [ADDR_W-1:0]      pc;
        logic [WIDE_DISP_W-1:0] disp;
        logic [CNT_W-1:0]       full_dec;
        logic [CNT_W-1:0]       low_dec;
        logic                   low_wrap;
        logic [CNT_W-1:0]       cnt_out;
        logic                   we;
        logic                   taken;
        logic [ADDR_W-1:0]      tgt;
        logic                   done;
    } lcu_regs_t;

    lcu_regs_t r_d, r_q;

    logic [CNT_W-1:0]  dc_full_dec;
    logic [CNT_W-1:0]  dc_low_dec;
    logic              dc_low_wrap;
    logic              dd_taken;
    logic              dd_we;
    logic [CNT_W-1:0]  dd_cnt;
    logic              dd_wide;
    logic [ADDR_W-1:0] tg_target;
    logic              busy;

    lcu_decrement #(
        .CNT_W (CNT_W),
        .LOW_W (LOW_W)
    ) u_dec (
        .cnt_i      (r_q.cnt),
        .full_dec_o (dc_full_dec),
        .low_dec_o  (dc_low_dec),
        .low_wrap_o (dc_low_wrap)
    );

    lcu_decide #(
        .CNT_W (CNT_W)
    ) u_decide (
        .op_i       (r_q.op),
        .cond_i     (r_q.cond),
        .zf_i       (r_q.zf),
        .cnt_i      (r_q.cnt),
        .full_dec_i (r_q.full_dec),
        .low_dec_i  (r_q.low_dec),
        .low_wrap_i (r_q.low_wrap),
        .taken_o    (dd_taken),
        .we_o       (dd_we),
        .cnt_o      (dd_cnt),
        .wide_o     (dd_wide)
    );

    lcu_target #(
        .ADDR_W       (ADDR_W),
        .WIDE_DISP_W  (WIDE_DISP_W),
        .SHORT_DISP_W (SHORT_DISP_W)
    ) u_target (
        .next_pc_i (r_q.pc),
        .disp_i    (r_q.disp),
        .wide_i    (dd_wide),
        .taken_i   (dd_taken),
        .target_o  (tg_target)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.we    = 1'b0;
        r_d.taken = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.op    = op_i;
                    r_d.cnt   = count_i;
                    r_d.cond  = cond_i;
                    r_d.zf    = zf_i;
                    r_d.pc    = next_pc_i;
                    r_d.disp  = disp_i;
                    r_d.state = ST_DEC;
                end
            end
            ST_DEC: begin
                r_d.full_dec = dc_full_dec;
                r_d.low_dec  = dc_low_dec;
                r_d.low_wrap = dc_low_wrap;
                r_d.state    = ST_DECIDE;
            end
            ST_DECIDE: begin
                r_d.cnt_out = dd_cnt;
                r_d.we      = dd_we;
                r_d.taken   = dd_taken;
                r_d.tgt     = tg_target;
                r_d.done    = 1'b1;
                r_d.state   = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.state != ST_IDLE);
    assign count_o    = r_q.cnt_out;
    assign count_we_o = r_q.we;
    assign taken_o    = r_q.taken;
    assign target_o   = r_q.tgt;
    assign done_o     = r_q.done;

endmodule

// File: rtl/lcu_checker.sv
module lcu_checker
    import lcu_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LOW_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             busy,
    input logic [2:0]       op_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] count_o,
    input logic             count_we_o,
    input logic             taken_o,
    input logic             done_o
);
    logic loop_family;
    assign loop_family = (op_q == OP_DECLOOP) || (op_q == OP_DECLOOP_ZS) ||
                         (op_q == OP_DECLOOP_ZC);

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10

    AST_START_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy) |=> ##2 done_o); // R10

    AST_WE_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_we_o |-> done_o); // R10

    AST_TAKEN_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> done_o); // R10

    AST_GUARD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && op_q == OP_CNTZ_GUARD) |-> !count_we_o); // R8

    AST_TESTDEC_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && op_q == OP_TESTDEC && count_we_o) |->
        (count_o[CNT_W-1:LOW_W] == cnt_q[CNT_W-1:LOW_W])); // R3

    AST_ZERO_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && loop_family && count_o == '0) |-> !taken_o); // R5

    AST_NOWRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !count_we_o) |-> (count_o == cnt_q)); // R12

endmodule

bind loop_ctrl_unit lcu_checker #(
    .CNT_W (CNT_W),
    .LOW_W (LOW_W)
) u_lcu_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .busy       (busy),
    .op_q       (r_q.op),
    .cnt_q      (r_q.cnt),
    .count_o    (count_o),
    .count_we_o (count_we_o),
    .taken_o    (taken_o),
    .done_o     (done_o)
);

// File: tb/test_loop_ctrl_unit.sv
module test_loop_ctrl_unit;

    localparam int          CNT_W  = 32;
    localparam int          ADDR_W = 32;
    localparam time         CLK_P  = 20ns;
    localparam logic [31:0] NPC    = 32'h0000_1000;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] cnt;
        logic        cond;
        logic        zf;
        logic [15:0] disp;
        logic        e_taken;
        logic        e_we;
        logic [31:0] e_cnt;
        logic [31:0] e_tgt;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_0005, 1'b1, 1'b0, 16'hFFF0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_1000}, // R2 R9
        '{3'd0, 32'h0000_0005, 1'b0, 1'b0, 16'hFFF0, 1'b1, 1'b1, 32'h0000_0004, 32'h0000_0FF0}, // R3 R4
        '{3'd0, 32'hABCD_0000, 1'b0, 1'b0, 16'h0010, 1'b0, 1'b1, 32'hABCD_FFFF, 32'h0000_1000}, // R3 wrap exit
        '{3'd0, 32'h1234_0001, 1'b0, 1'b1, 16'h0100, 1'b1, 1'b1, 32'h1234_0000, 32'h0000_1100}, // R3 zero branches
        '{3'd0, 32'h0000_0003, 1'b0, 1'b0, 16'h7FFF, 1'b1, 1'b1, 32'h0000_0002, 32'h0000_8FFF}, // R4
        '{3'd1, 32'h0000_0003, 1'b1, 1'b0, 16'h12F0, 1'b1, 1'b1, 32'h0000_0002, 32'h0000_0FF0}, // R5 R6
        '{3'd1, 32'h0000_0001, 1'b1, 1'b1, 16'h0010, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_1000}, // R5 R9
        '{3'd1, 32'h0000_0000, 1'b0, 1'b0, 16'h0005, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_1005}, // R5 wrap
        '{3'd1, 32'h0001_0000, 1'b0, 1'b0, 16'h0010, 1'b1, 1'b1, 32'h0000_FFFF, 32'h0000_1010}, // R5 full width
        '{3'd2, 32'h0000_0005, 1'b0, 1'b1, 16'h0008, 1'b1, 1'b1, 32'h0000_0004, 32'h0000_1008}, // R7
        '{3'd2, 32'h0000_0005, 1'b0, 1'b0, 16'h0008, 1'b0, 1'b1, 32'h0000_0004, 32'h0000_1000}, // R7
        '{3'd3, 32'h0000_0005, 1'b0, 1'b0, 16'h0080, 1'b1, 1'b1, 32'h0000_0004, 32'h0000_0F80}, // R7 R6
        '{3'd3, 32'h0000_0005, 1'b0, 1'b1, 16'h0080, 1'b0, 1'b1, 32'h0000_0004, 32'h0000_1000}, // R7
        '{3'd2, 32'h0000_0001, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_1000}, // R7
        '{3'd4, 32'h0000_0000, 1'b1, 1'b1, 16'h307F, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_107F}, // R8 R6
        '{3'd4, 32'h0000_0007, 1'b0, 1'b0, 16'h007F, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_1000}, // R8
        '{3'd0, 32'h0000_0000, 1'b1, 1'b0, 16'h0010, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_1000}, // R2 count zero
        '{3'd7, 32'h0000_0009, 1'b0, 1'b0, 16'h0010, 1'b0, 1'b0, 32'h0000_0009, 32'h0000_1000}, // R12
        '{3'd5, 32'h0000_0000, 1'b0, 1'b1, 16'h0004, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_1000}  // R12
    };

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              start_i = 1'b0;
    logic [2:0]        op_i = '0;
    logic [CNT_W-1:0]  count_i = '0;
    logic              cond_i = 1'b0;
    logic              zf_i = 1'b0;
    logic [ADDR_W-1:0] next_pc_i = '0;
    logic [15:0]       disp_i = '0;
    logic [CNT_W-1:0]  count_o;
    logic              count_we_o;
    logic              taken_o;
    logic [ADDR_W-1:0] target_o;
    logic              done_o;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #(CLK_P/2) clk_i = ~clk_i;

    loop_ctrl_unit i_loop_ctrl_unit (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .op_i       (op_i),
        .count_i    (count_i),
        .cond_i     (cond_i),
        .zf_i       (zf_i),
        .next_pc_i  (next_pc_i),
        .disp_i     (disp_i),
        .count_o    (count_o),
        .count_we_o (count_we_o),
        .taken_o    (taken_o),
        .target_o   (target_o),
        .done_o     (done_o)
    );

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0:    return "R3";
            3'd1:    return "R5";
            3'd2:    return "R7";
            3'd3:    return "R7";
            3'd4:    return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] cnt,
                         input logic cond, input logic zf, input logic [15:0] disp);
        op_i      = op;
        count_i   = cnt;
        cond_i    = cond;
        zf_i      = zf;
        disp_i    = disp;
        next_pc_i = NPC;
        start_i   = 1'b1;
    endtask

    initial begin
        #(CLK_P * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state, held and after release
        repeat (3) @(negedge clk_i);
        chk("R1", "done in reset", 32'(done_o), 32'd0);
        chk("R1", "we in reset", 32'(count_we_o), 32'd0);
        chk("R1", "count in reset", count_o, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1", "taken after reset", 32'(taken_o), 32'd0);
        chk("R1", "target after reset", target_o, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].cnt, VECS[i].cond, VECS[i].zf, VECS[i].disp);
            @(negedge clk_i);
            start_i = 1'b0;
            chk("R10", "done early", 32'(done_o), 32'd0);
            @(negedge clk_i);
            chk("R10", "done early", 32'(done_o), 32'd0);
            @(negedge clk_i);
            chk("R10", "done", 32'(done_o), 32'd1);
            chk(tag_of(VECS[i].op), $sformatf("v%0d taken", i), 32'(taken_o), 32'(VECS[i].e_taken));
            chk(tag_of(VECS[i].op), $sformatf("v%0d we", i), 32'(count_we_o), 32'(VECS[i].e_we));
            chk(tag_of(VECS[i].op), $sformatf("v%0d count", i), count_o, VECS[i].e_cnt);
            chk(tag_of(VECS[i].op), $sformatf("v%0d target", i), target_o, VECS[i].e_tgt);
            @(negedge clk_i);
            chk("R10", "done pulse width", 32'(done_o), 32'd0);
            chk("R10", "we without done", 32'(count_we_o), 32'd0);
        end

        // R11: start while busy is ignored
        drive(3'd1, 32'd3, 1'b0, 1'b0, 16'h0004);
        @(negedge clk_i);
        drive(3'd4, 32'd0, 1'b0, 1'b0, 16'h0040);
        @(negedge clk_i);
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R11", "done", 32'(done_o), 32'd1);
        chk("R11", "taken", 32'(taken_o), 32'd1);
        chk("R11", "we", 32'(count_we_o), 32'd1);
        chk("R11", "count", count_o, 32'd2);
        chk("R11", "target", target_o, 32'h0000_1004);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk_i);
            chk("R11", "no second done", 32'(done_o), 32'd0);
        end

        // R1: reset in the middle of an operation
        drive(3'd1, 32'd9, 1'b0, 1'b0, 16'h0004);
        @(negedge clk_i);
        start_i = 1'b0;
        rst_ni  = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk_i);
            chk("R1", "no done after reset", 32'(done_o), 32'd0);
        end
        chk("R1", "count cleared", count_o, 32'd0);
        chk("R1", "target cleared", target_o, 32'd0);

        finish_run();
    end

endmodule